// File: doc/BRIEF.md
# Two-Bank Graphics DRAM Command Front End

This block sits directly behind the command pins of a two-bank graphics DRAM. It samples the strobes, the bank pick line and an 11-bit address on every rising clock edge. It turns them into one decoded command and keeps a per-bank open or closed state. The block also keeps the last opened row, the last accessed column and two mode words. A controller or a device model uses the registered outputs to find out what was issued, to which bank, and whether the command was allowed.

An extra strobe, `spfn`, marks special variants. On an open it enables masked writes for that bank. It turns a write into a block write, and it sends a mode load to the second mode word. The same address bit has two meanings: on a column access it requests auto-precharge, and on a precharge it closes both banks. A clock-enable input can freeze the whole block. If it drops while both banks are closed, the block enters power-down, and it leaves power-down as soon as the enable rises.

Top module: `gram_cmd_front`

## Requirements
- R1: When `sel_n` is sampled high, the edge decodes as no-operation (`cmd_code` 0) and no bank is opened, closed or marked illegal by it.
- R2: With `sel_n` low, strobes {rowstb_n,colstb_n,wrstb_n} decode as follows: 011 → open (code 1, or 2 with `spfn` high); 010 → precharge (3); 101 → read (4); 100 → write (5, or block write 6 with `spfn` high); 000 → mode load (7, or special mode load 8 with `spfn` high); 001 → refresh (9); 111 and 110 → no-operation (0). `cmd_code` and `cmd_bank` show the command one cycle after the edge that sampled it.
- R3: A legal open sets the bank's bit in `bank_active`, copies `addr_in` into `row_latch`, and sets that bank's `bank_mask` bit to the value of `spfn`.
- R4: A legal read, write or block write copies `addr_in[7:0]` into `col_latch`. `auto_pre` shows `addr_in[8]` for column accesses and precharges, and shows 0 for all other commands.
- R5: A precharge with `addr_in[8]` low closes only the bank named by `bank_pick`. With `addr_in[8]` high it closes both banks.
- R6: An open aimed at an active bank, or a column access aimed at a closed bank, raises `illegal` for one cycle. It changes neither that bank's state nor `row_latch` nor `col_latch`.
- R7: A legal column access with `addr_in[8]` high leaves its bank active for one cycle, and the bank is closed after the next edge. That next edge treats the bank as closed, so an open to it is legal there.
- R8: A mode load stores {bank_pick, addr_in} into `mode_word`, and a special mode load stores it into `smode_word`. Neither load touches the other word.
- R9: `clk_en` sampled low at an edge lets that edge act normally and freezes every output and bank state from the following edge on, for as long as it stays low. The edge that samples it high again is still frozen.
- R10: `clk_en` sampled low at an edge after which both banks are closed raises `pwr_down`. `pwr_down` drops combinationally the moment `clk_en` goes high.
- R11: Synchronous reset clears all outputs to 0 and leaves the block running (not frozen).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Clock enable; low freezes the block from the next edge |
| sel_n | input | 1 | Device select, active low; high masks the command |
| rowstb_n | input | 1 | Row strobe, active low |
| colstb_n | input | 1 | Column strobe, active low |
| wrstb_n | input | 1 | Write strobe, active low |
| spfn | input | 1 | Special-function strobe |
| bank_pick | input | 1 | Target bank; top bit of the mode words |
| addr_in | input | 11 | Row address, column address with bit 8 flag, or mode op-code |
| cmd_code | output | 4 | Decoded command of the last processed edge |
| cmd_bank | output | 1 | Bank pick of the last processed edge |
| auto_pre | output | 1 | Address bit 8 for column accesses and precharges |
| illegal | output | 1 | One-cycle flag for an illegal open or column access |
| bank_active | output | 2 | Per-bank open state |
| bank_mask | output | 2 | Per-bank masked-write enable from the last open |
| row_latch | output | 11 | Row of the last legal open |
| col_latch | output | 8 | Column of the last legal column access |
| mode_word | output | 12 | Last mode load value |
| smode_word | output | 12 | Last special mode load value |
| pwr_down | output | 1 | Power-down indicator |

## Verification
Two things can happen at the same edge: the delayed close from an auto-precharge access and a new command that targets either bank. The bench provokes this by issuing an open to the other bank, which is active and so illegal, right after a write with auto-precharge. It also re-opens the same bank right after a read with auto-precharge. The scoreboard judges the outcome by `bank_active`: the retiring bank must show closed in the first case, and it must show open again, with no `illegal`, in the second.

// File: rtl/gram_pkg.sv
package gram_pkg;

    typedef enum logic [3:0] {
        CMD_NOP      = 4'd0,
        CMD_OPEN     = 4'd1,
        CMD_OPEN_MSK = 4'd2,
        CMD_PRE      = 4'd3,
        CMD_READ     = 4'd4,
        CMD_WRITE    = 4'd5,
        CMD_BLOCK_WR = 4'd6,
        CMD_MODE     = 4'd7,
        CMD_SMODE    = 4'd8,
        CMD_REFRESH  = 4'd9
    } cmd_e;

    typedef struct packed {
        cmd_e op;
        logic ap;
        logic pre_all;
    } dec_t;

    function automatic cmd_e decode_strobes(input logic sel_n, input logic r_n,
                                            input logic c_n, input logic w_n,
                                            input logic sp);
        cmd_e op;
        op = CMD_NOP;
        if (!sel_n) begin
            case ({r_n, c_n, w_n})
                3'b011:  op = sp ? CMD_OPEN_MSK : CMD_OPEN;
                3'b010:  op = CMD_PRE;
                3'b101:  op = CMD_READ;
                3'b100:  op = sp ? CMD_BLOCK_WR : CMD_WRITE;
                3'b000:  op = sp ? CMD_SMODE : CMD_MODE;
                3'b001:  op = CMD_REFRESH;
                default: op = CMD_NOP;
            endcase
        end
        return op;
    endfunction

    function automatic logic is_open(input cmd_e op);
        return (op == CMD_OPEN) || (op == CMD_OPEN_MSK);
    endfunction

    function automatic logic is_column(input cmd_e op);
        return (op == CMD_READ) || (op == CMD_WRITE) || (op == CMD_BLOCK_WR);
    endfunction

endpackage

// File: rtl/gram_cmd_decode.sv
module gram_cmd_decode
    import gram_pkg::*;
#(
    parameter int unsigned BANK_W = 1,
    localparam int unsigned NUM_BANKS = 1 << BANK_W
) (
    input  logic                 sel_n,
    input  logic                 rowstb_n,
    input  logic                 colstb_n,
    input  logic                 wrstb_n,
    input  logic                 spfn,
    input  logic [BANK_W-1:0]    bank_pick,
    input  logic                 flag_bit,
    output dec_t                 dec,
    output logic [NUM_BANKS-1:0] hit
);

    cmd_e op;

    always_comb begin
        op          = decode_strobes(sel_n, rowstb_n, colstb_n, wrstb_n, spfn);
        dec.op      = op;
        dec.ap      = (is_column(op) || op == CMD_PRE) ? flag_bit : 1'b0;
        dec.pre_all = (op == CMD_PRE) && flag_bit;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
        assign hit[b] = (bank_pick == BANK_W'(b));
    end

endmodule

// File: rtl/gram_bank_slot.sv
module gram_bank_slot
    import gram_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic hit,
    input  cmd_e op,
    input  logic ap,
    input  logic pre_all,
    output logic active,
    output logic mask,
    output logic idle_next,
    output logic bad
);

    logic active_q, pend_q, mask_q;
    logic active_n, pend_n, mask_n;
    logic eff_idle;

    assign eff_idle = !active_q || pend_q;
    assign bad      = hit && ((is_open(op) && !eff_idle) || (is_column(op) && eff_idle));

    always_comb begin
        active_n = active_q && !pend_q;
        pend_n   = 1'b0;
        mask_n   = mask_q;
        if (op == CMD_PRE && (hit || pre_all)) begin
            active_n = 1'b0;
        end else if (hit && is_open(op) && eff_idle) begin
            active_n = 1'b1;
            mask_n   = (op == CMD_OPEN_MSK);
        end else if (hit && is_column(op) && !eff_idle && ap) begin
            pend_n   = 1'b1;
        end
    end

    assign idle_next = !active_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            pend_q   <= 1'b0;
            mask_q   <= 1'b0;
        end else if (run) begin
            active_q <= active_n;
            pend_q   <= pend_n;
            mask_q   <= mask_n;
        end
    end

    assign active = active_q;
    assign mask   = mask_q;

endmodule

// File: rtl/gram_clk_hold.sv
module gram_clk_hold (
    input  logic clk,
    input  logic rst,
    input  logic clk_en,
    input  logic all_idle_next,
    output logic run,
    output logic pwr_down
);

    logic run_q, pd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b1;
            pd_q  <= 1'b0;
        end else begin
            run_q <= clk_en;
            if (clk_en)
                pd_q <= 1'b0;
            else if (run_q && all_idle_next)
                pd_q <= 1'b1;
        end
    end

    assign run      = run_q;
    assign pwr_down = pd_q && !clk_en;

endmodule

// File: rtl/gram_cmd_front.sv
module gram_cmd_front
    import gram_pkg::*;
#(
    parameter int unsigned BANK_W = 1,
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned COL_W  = 8,
    parameter int unsigned AP_BIT = 8,
    localparam int unsigned NUM_BANKS = 1 << BANK_W,
    localparam int unsigned MODE_W    = BANK_W + ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clk_en,
    input  logic                 sel_n,
    input  logic                 rowstb_n,
    input  logic                 colstb_n,
    input  logic                 wrstb_n,
    input  logic                 spfn,
    input  logic [BANK_W-1:0]    bank_pick,
    input  logic [ADDR_W-1:0]    addr_in,
    output logic [3:0]           cmd_code,
    output logic [BANK_W-1:0]    cmd_bank,
    output logic                 auto_pre,
    output logic                 illegal,
    output logic [NUM_BANKS-1:0] bank_active,
    output logic [NUM_BANKS-1:0] bank_mask,
    output logic [ADDR_W-1:0]    row_latch,
    output logic [COL_W-1:0]     col_latch,
    output logic [MODE_W-1:0]    mode_word,
    output logic [MODE_W-1:0]    smode_word,
    output logic                 pwr_down
);

    dec_t                 dec;
    logic [NUM_BANKS-1:0] hit, idle_nx, bad_v;
    logic                 run_q, any_bad;

    cmd_e                 op_q;
    logic [BANK_W-1:0]    bank_q;
    logic                 ap_q, ill_q;
    logic [ADDR_W-1:0]    row_q;
    logic [COL_W-1:0]     col_q;
    logic [MODE_W-1:0]    mode_q, smode_q;

    gram_cmd_decode #(.BANK_W(BANK_W)) i_dec (
        .sel_n    (sel_n),
        .rowstb_n (rowstb_n),
        .colstb_n (colstb_n),
        .wrstb_n  (wrstb_n),
        .spfn     (spfn),
        .bank_pick(bank_pick),
        .flag_bit (addr_in[AP_BIT]),
        .dec      (dec),
        .hit      (hit)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gram_bank_slot i_slot (
            .clk      (clk),
            .rst      (rst),
            .run      (run_q),
            .hit      (hit[b]),
            .op       (dec.op),
            .ap       (dec.ap),
            .pre_all  (dec.pre_all),
            .active   (bank_active[b]),
            .mask     (bank_mask[b]),
            .idle_next(idle_nx[b]),
            .bad      (bad_v[b])
        );
    end

    gram_clk_hold i_hold (
        .clk          (clk),
        .rst          (rst),
        .clk_en       (clk_en),
        .all_idle_next(&idle_nx),
        .run          (run_q),
        .pwr_down     (pwr_down)
    );

    assign any_bad = |bad_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= CMD_NOP;
            bank_q  <= '0;
            ap_q    <= 1'b0;
            ill_q   <= 1'b0;
            row_q   <= '0;
            col_q   <= '0;
            mode_q  <= '0;
            smode_q <= '0;
        end else if (run_q) begin
            op_q   <= dec.op;
            bank_q <= bank_pick;
            ap_q   <= dec.ap;
            ill_q  <= any_bad;
            if (is_open(dec.op) && !any_bad)
                row_q <= addr_in;
            if (is_column(dec.op) && !any_bad)
                col_q <= addr_in[COL_W-1:0];
            if (dec.op == CMD_MODE)
                mode_q <= {bank_pick, addr_in};
            if (dec.op == CMD_SMODE)
                smode_q <= {bank_pick, addr_in};
        end
    end

    assign cmd_code   = op_q;
    assign cmd_bank   = bank_q;
    assign auto_pre   = ap_q;
    assign illegal    = ill_q;
    assign row_latch  = row_q;
    assign col_latch  = col_q;
    assign mode_word  = mode_q;
    assign smode_word = smode_q;

endmodule

// File: rtl/gram_front_chk.sv
module gram_front_chk (
    input logic        clk,
    input logic        rst,
    input logic        clk_en,
    input logic        sel_n,
    input logic        run_q,
    input logic [3:0]  cmd_code,
    input logic        cmd_bank,
    input logic        auto_pre,
    input logic        illegal,
    input logic [1:0]  bank_active,
    input logic [10:0] row_latch,
    input logic        pwr_down
);

    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)
            age <= 2'd0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    // R1
    masked_nop_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_n && run_q) |=> (cmd_code == 4'd0));

    // R6
    illegal_open_row_chk: assert property (@(posedge clk) disable iff (rst)
        ((age != 2'd0) && illegal && (cmd_code == 4'd1 || cmd_code == 4'd2))
        |-> (row_latch == $past(row_latch)));

    // R7
    ap_retire_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && !illegal && auto_pre && (cmd_code == 4'd4 || cmd_code == 4'd5 || cmd_code == 4'd6))
        |=> (!bank_active[$past(cmd_bank)] || cmd_code == 4'd1 || cmd_code == 4'd2));

    // R9
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((age >= 2'd2) && !$past(clk_en, 2))
        |-> ($stable(row_latch) && $stable(cmd_code) && $stable(bank_active)));

    // R10
    pd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_down |-> (bank_active == 2'b00));

endmodule

bind gram_cmd_front gram_front_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .clk_en     (clk_en),
    .sel_n      (sel_n),
    .run_q      (run_q),
    .cmd_code   (cmd_code),
    .cmd_bank   (cmd_bank),
    .auto_pre   (auto_pre),
    .illegal    (illegal),
    .bank_active(bank_active),
    .row_latch  (row_latch),
    .pwr_down   (pwr_down)
);

// File: tb/test_gram_cmd_front.sv
module test_gram_cmd_front;

    localparam int K_NOPSEL = 0, K_NOP = 1, K_OPEN = 2, K_OPENM = 3, K_PRE = 4,
                   K_RD = 5, K_WR = 6, K_BW = 7, K_MODE = 8, K_SMODE = 9, K_REF = 10;

    typedef struct packed {
        logic [3:0]  cmd;
        logic        bank;
        logic        ap;
        logic        ill;
        logic [1:0]  act;
        logic [1:0]  mask;
        logic [10:0] row;
        logic [7:0]  col;
        logic        pwr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_en = 1'b1;
    logic        sel_n = 1'b1, rowstb_n = 1'b1, colstb_n = 1'b1, wrstb_n = 1'b1, spfn = 1'b0;
    logic        bank_pick = 1'b0;
    logic [10:0] addr_in = '0;
    logic [3:0]  cmd_code;
    logic        cmd_bank, auto_pre, illegal, pwr_down;
    logic [1:0]  bank_active, bank_mask;
    logic [10:0] row_latch;
    logic [7:0]  col_latch;
    logic [11:0] mode_word, smode_word;

    int   total = 0;
    int   bad = 0;
    bit   ended = 1'b0;
    exp_t  q[$];
    string tq[$];

    always #4 clk = ~clk;

    gram_cmd_front i_gram_cmd_front (
        .clk(clk), .rst(rst), .clk_en(clk_en), .sel_n(sel_n),
        .rowstb_n(rowstb_n), .colstb_n(colstb_n), .wrstb_n(wrstb_n), .spfn(spfn),
        .bank_pick(bank_pick), .addr_in(addr_in),
        .cmd_code(cmd_code), .cmd_bank(cmd_bank), .auto_pre(auto_pre), .illegal(illegal),
        .bank_active(bank_active), .bank_mask(bank_mask), .row_latch(row_latch),
        .col_latch(col_latch), .mode_word(mode_word), .smode_word(smode_word),
        .pwr_down(pwr_down)
    );

    function automatic exp_t e(input logic [3:0] c, input logic b, input logic ap,
                               input logic il, input logic [1:0] ac, input logic [1:0] mk,
                               input logic [10:0] r, input logic [7:0] cl, input logic p);
        return {c, b, ap, il, ac, mk, r, cl, p};
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] got,
                         input logic [31:0] want);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, want);
        end
    endtask

    task automatic step(input int kind, input logic b, input logic [10:0] a,
                        input logic en, input exp_t x, input string tag);
        @(negedge clk);
        sel_n = 1'b0;
        spfn  = 1'b0;
        case (kind)
            K_NOPSEL: begin sel_n = 1'b1; {rowstb_n, colstb_n, wrstb_n} = 3'b000; end
            K_NOP:    {rowstb_n, colstb_n, wrstb_n} = 3'b111;
            K_OPEN:   {rowstb_n, colstb_n, wrstb_n} = 3'b011;
            K_OPENM:  begin {rowstb_n, colstb_n, wrstb_n} = 3'b011; spfn = 1'b1; end
            K_PRE:    {rowstb_n, colstb_n, wrstb_n} = 3'b010;
            K_RD:     {rowstb_n, colstb_n, wrstb_n} = 3'b101;
            K_WR:     {rowstb_n, colstb_n, wrstb_n} = 3'b100;
            K_BW:     begin {rowstb_n, colstb_n, wrstb_n} = 3'b100; spfn = 1'b1; end
            K_MODE:   {rowstb_n, colstb_n, wrstb_n} = 3'b000;
            K_SMODE:  begin {rowstb_n, colstb_n, wrstb_n} = 3'b000; spfn = 1'b1; end
            default:  {rowstb_n, colstb_n, wrstb_n} = 3'b001;
        endcase
        bank_pick = b;
        addr_in   = a;
        clk_en    = en;
        q.push_back(x);
        tq.push_back(tag);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Monitor: pops one expected item per edge, sampling 2 ns after it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t  x;
                exp_t  g;
                string t;
                x = q.pop_front();
                t = tq.pop_front();
                g = {cmd_code, cmd_bank, auto_pre, illegal, bank_active, bank_mask,
                     row_latch, col_latch, pwr_down};
                total++;
                if (g !== x) begin
                    bad++;
                    $display("FAIL %s: got %h expected %h", t, g, x);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(cmd_code == 4'd0 && bank_active == 2'b00 && row_latch == 11'd0 &&
              mode_word == 12'd0 && !pwr_down && !illegal, "R11 reset",
              {cmd_code, bank_active, row_latch, pwr_down}, 32'd0);
        rst = 1'b0;

        step(K_NOPSEL, 0, 11'h000, 1, e(0,0,0,0,2'b00,2'b00,11'h000,8'h00,0), "R1 masked");
        step(K_OPEN,   0, 11'h5A3, 1, e(1,0,0,0,2'b01,2'b00,11'h5A3,8'h00,0), "R3 open b0");
        step(K_OPENM,  1, 11'h7FF, 1, e(2,1,0,0,2'b11,2'b10,11'h7FF,8'h00,0), "R3 open masked b1");
        step(K_RD,     0, 11'h0C5, 1, e(4,0,0,0,2'b11,2'b10,11'h7FF,8'hC5,0), "R4 read");
        step(K_WR,     1, 11'h13C, 1, e(5,1,1,0,2'b11,2'b10,11'h7FF,8'h3C,0), "R4 write ap");
        // R6 + R7: illegal open of b0 while b1 retires
        step(K_OPEN,   0, 11'h555, 1, e(1,0,0,1,2'b01,2'b10,11'h7FF,8'h3C,0), "R6 R7 open active");
        step(K_BW,     1, 11'h0AB, 1, e(6,1,0,1,2'b01,2'b10,11'h7FF,8'h3C,0), "R6 block wr idle");
        step(K_PRE,    0, 11'h000, 1, e(3,0,0,0,2'b00,2'b10,11'h7FF,8'h3C,0), "R5 single pre");
        step(K_OPEN,   1, 11'h001, 1, e(1,1,0,0,2'b10,2'b00,11'h001,8'h3C,0), "R3 mask clear");
        step(K_OPEN,   0, 11'h002, 1, e(1,0,0,0,2'b11,2'b00,11'h002,8'h3C,0), "R3 open b0");
        step(K_PRE,    0, 11'h100, 1, e(3,0,1,0,2'b00,2'b00,11'h002,8'h3C,0), "R5 pre all");
        step(K_RD,     0, 11'h000, 1, e(4,0,0,1,2'b00,2'b00,11'h002,8'h3C,0), "R6 read idle");
        step(K_MODE,   1, 11'h2A5, 1, e(7,1,0,0,2'b00,2'b00,11'h002,8'h3C,0), "R2 mode");
        step(K_SMODE,  0, 11'h033, 1, e(8,0,0,0,2'b00,2'b00,11'h002,8'h3C,0), "R2 smode");
        step(K_REF,    0, 11'h000, 1, e(9,0,0,0,2'b00,2'b00,11'h002,8'h3C,0), "R2 refresh");
        step(K_NOP,    1, 11'h000, 1, e(0,1,0,0,2'b00,2'b00,11'h002,8'h3C,0), "R2 nop");
        step(K_OPEN,   0, 11'h444, 1, e(1,0,0,0,2'b01,2'b00,11'h444,8'h3C,0), "R3 open");
        step(K_RD,     0, 11'h1FF, 1, e(4,0,1,0,2'b01,2'b00,11'h444,8'hFF,0), "R7 read ap");
        step(K_OPEN,   0, 11'h123, 1, e(1,0,0,0,2'b01,2'b00,11'h123,8'hFF,0), "R7 reopen");
        // R9 freeze
        step(K_OPEN,   1, 11'h0AA, 0, e(1,1,0,0,2'b11,2'b00,11'h0AA,8'hFF,0), "R9 last live");
        step(K_PRE,    0, 11'h100, 0, e(1,1,0,0,2'b11,2'b00,11'h0AA,8'hFF,0), "R9 frozen");
        step(K_PRE,    0, 11'h100, 1, e(1,1,0,0,2'b11,2'b00,11'h0AA,8'hFF,0), "R9 frozen rise");
        step(K_NOP,    0, 11'h000, 1, e(0,0,0,0,2'b11,2'b00,11'h0AA,8'hFF,0), "R9 resumed");
        // R10 power-down
        step(K_PRE,    0, 11'h100, 1, e(3,0,1,0,2'b00,2'b00,11'h0AA,8'hFF,0), "R5 pre all");
        step(K_NOP,    0, 11'h000, 0, e(0,0,0,0,2'b00,2'b00,11'h0AA,8'hFF,1), "R10 enter");
        step(K_OPEN,   0, 11'h007, 0, e(0,0,0,0,2'b00,2'b00,11'h0AA,8'hFF,1), "R10 held");
        step(K_NOP,    0, 11'h000, 1, e(0,0,0,0,2'b00,2'b00,11'h0AA,8'hFF,0), "R10 exit edge");
        #1;
        check(pwr_down == 1'b0, "R10 async exit", {31'd0, pwr_down}, 32'd0);
        step(K_OPEN,   0, 11'h321, 1, e(1,0,0,0,2'b01,2'b00,11'h321,8'hFF,0), "R10 after exit");

        wait (q.size() == 0);
        @(negedge clk);
        check(mode_word == 12'hAA5, "R8 mode word", {20'd0, mode_word}, 32'hAA5);
        check(smode_word == 12'h033, "R8 smode word", {20'd0, smode_word}, 32'h033);
        finish_run();
    end

endmodule